// File: doc/BRIEF.md
# Multi-Format Slave Audio Serializer

This block is the transmit side of a slave-mode digital audio port. A host pushes stereo sample pairs into it over a valid/ready interface. The block shifts each word out MSB first on a single data line. It does not make any timing of its own: an external bit clock and an external frame sync set the bit slots and the word starts. The block samples both of those signals with its own system clock and acts on their edges.

Three framings are supported. In two-channel framing with a one-bit delay, the frame sync is low during the left word. In two-channel framing without delay, the frame sync is high during the left word. In pulse framing, one sync pulse per frame starts the left word, and the right word follows it with no gap. The word size, the bit-clock edge on which the receiver captures, the pulse-mode delay, and the underrun policy can each be selected.

Back-pressure rules: `in_ready` is high for exactly one clock cycle at the start of each left word, and at no other time. A pair is accepted only in a cycle where `in_valid` and `in_ready` are both high. The source must therefore keep `in_valid`, `in_left` and `in_right` stable until it sees that handshake. If no pair is offered at the start of a left word, the frame is sent without a new pair. The block then either sends zeros or repeats the last pair, and it raises a sticky flag.

Both `dclk` and `dfs` must be synchronous to `clk`. Each `dclk` level must last at least 4 `clk` cycles. `dfs` must change in the same `clk` cycle as the launch edge of `dclk`.

Top module: `aser_slave_tx`

## Requirements
- R1: After reset `sdata`, `in_ready` and `underrun` are 0. `sdata` stays 0 until the first word start, and the block drives no pin other than `sdata`, `in_ready` and `underrun`.
- R2: When `cfg_fmt`=0 (delayed two-channel), every `dfs` change starts a word: `dfs`=0 selects left and `dfs`=1 selects right. The MSB is valid at the second capture edge after the change.
- R3: When `cfg_fmt`=1 (aligned two-channel), every `dfs` change starts a word: `dfs`=1 selects left and `dfs`=0 selects right. The MSB is valid at the first capture edge after the change.
- R4: When `cfg_fmt`=2 or 3 (pulse), only a rising `dfs` starts a frame. The left word is sent first, and the right MSB follows the left LSB in the very next slot. With `cfg_dsp_late`=0 the left MSB is valid at the first capture edge after the rise; with `cfg_dsp_late`=1 it is valid at the second.
- R5: `cfg_wlen` selects the word size: 0 gives 8 bits, 1 gives 16, 2 gives 20 and 3 gives 24. Samples are MSB-aligned in the 24-bit inputs, so bit 23 is sent first, and exactly that many bits go out, MSB first.
- R6: Slots after the LSB carry 0, whatever their number. A new word is never misaligned by them. In delayed framing with no idle slot, the previous LSB still occupies the first slot after the `dfs` change.
- R7: `cfg_fall_capture`=0 means the receiver captures on rising `dclk`, and `sdata` changes only after falling edges. With 1, the edges are swapped. Each bit is held from one launch edge to the next.
- R8: `in_ready` is a one-cycle pulse at each left-word start. A pair is accepted exactly when `in_valid` and `in_ready` are both high.
- R9: If `in_valid` is low at a left-word start, `underrun` becomes 1 and stays 1 until `underrun_clr`. That frame sends zeros when `cfg_hold_last`=0, and repeats the last accepted pair when it is 1.
- R10: All `cfg_*` inputs are taken at left-word starts only. A change at any other time leaves the words of the frame in progress unchanged and applies from the next left-word start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all inputs |
| rst_n | input | 1 | Asynchronous active-low reset |
| dclk | input | 1 | External bit clock |
| dfs | input | 1 | External frame sync |
| cfg_fmt | input | 2 | 0 delayed two-channel, 1 aligned two-channel, 2/3 pulse |
| cfg_fall_capture | input | 1 | 1: receiver captures on falling `dclk` |
| cfg_dsp_late | input | 1 | Pulse framing: MSB on second capture edge |
| cfg_wlen | input | 2 | Word size code (8/16/20/24) |
| cfg_hold_last | input | 1 | On underrun, repeat last pair instead of zeros |
| in_valid | input | 1 | Source offers a stereo pair |
| in_left | input | 24 | Left sample, MSB-aligned |
| in_right | input | 24 | Right sample, MSB-aligned |
| in_ready | output | 1 | One-cycle pulse at left-word start |
| underrun_clr | input | 1 | Clears the underrun flag |
| sdata | output | 1 | Serial audio data |
| underrun | output | 1 | Sticky: a frame started without a pair |

## Verification
On every cycle, the assertions check these properties:
- `sdata` changes only on a launch or word-start event.
- The bit counter stays inside the word.
- The ready pulse lasts one cycle.
- The underrun flag sets on a missed handshake and holds until it is cleared.
- The active configuration cannot move between left-word starts.

The bench's scenarios are the only way to show bit placement against the frame sync in each framing. They also cover the first-edge and second-edge MSB, the previous LSB carried across a back-to-back delayed frame, and the zero and repeat underrun policies. The last behaviour they show is a configuration change made mid-frame that takes effect one frame later.

// File: rtl/aser_pkg.sv
package aser_pkg;
  localparam logic [1:0] FMT_DLY = 2'd0;  // delayed two-channel
  localparam logic [1:0] FMT_ALN = 2'd1;  // aligned two-channel
  localparam int MAX_WORD = 24;

  function automatic int unsigned word_bits(input logic [1:0] code);
    case (code)
      2'd0:    return 8;
      2'd1:    return 16;
      2'd2:    return 20;
      default: return 24;
    endcase
  endfunction
endpackage

// File: rtl/aser_edge_mon.sv
module aser_edge_mon (
  input  logic clk,
  input  logic rst_n,
  input  logic dclk,
  input  logic dfs,
  input  logic fall_cap,
  input  logic pulse_mode,
  output logic launch_ev,
  output logic frame_ev,
  output logic dfs_lvl
);
  logic dclk_q, dclk_qq, dfs_q, dfs_qq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dclk_q  <= 1'b0;
      dclk_qq <= 1'b0;
      dfs_q   <= 1'b0;
      dfs_qq  <= 1'b0;
    end else begin
      dclk_q  <= dclk;
      dclk_qq <= dclk_q;
      dfs_q   <= dfs;
      dfs_qq  <= dfs_q;
    end
  end

  // launch edge: dclk moves to the level opposite the capture level
  assign launch_ev = (dclk_q ^ dclk_qq) && (dclk_q == fall_cap);
  assign frame_ev  = pulse_mode ? (dfs_q & ~dfs_qq) : (dfs_q ^ dfs_qq);
  assign dfs_lvl   = dfs_q;

  // R1: a word-start event never lasts two cycles
  a_r1_frame_single: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ev |=> !frame_ev);
endmodule

// File: rtl/aser_shift_eng.sv
module aser_shift_eng #(
  parameter int DATA_W = 24,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch_ev,
  input  logic              frame_ev,
  input  logic              one_slot_delay,
  input  logic [CNT_W-1:0]  nbits,
  input  logic [DATA_W-1:0] word_a,
  input  logic [DATA_W-1:0] word_b,
  input  logic              word_b_en,
  output logic              sdata
);
  logic [DATA_W-1:0] sh, pend_w, nxt_w;
  logic [CNT_W-1:0]  cnt, wbits;
  logic              pend, nxt_v, sd;

  logic [DATA_W-1:0] adv_sh;
  logic [CNT_W-1:0]  adv_cnt;
  logic              adv_sd, adv_nxt_v;

  // one launch step of the word in flight (or the chained second word)
  always_comb begin
    adv_sd    = 1'b0;
    adv_sh    = sh << 1;
    adv_cnt   = cnt;
    adv_nxt_v = nxt_v;
    if (cnt != '0) begin
      adv_sd  = sh[DATA_W-1];
      adv_cnt = cnt - CNT_W'(1);
    end else if (nxt_v) begin
      adv_sd    = nxt_w[DATA_W-1];
      adv_sh    = nxt_w << 1;
      adv_cnt   = wbits - CNT_W'(1);
      adv_nxt_v = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh     <= '0;
      pend_w <= '0;
      nxt_w  <= '0;
      cnt    <= '0;
      wbits  <= '0;
      pend   <= 1'b0;
      nxt_v  <= 1'b0;
      sd     <= 1'b0;
    end else if (frame_ev) begin
      if (!one_slot_delay) begin
        sd   <= word_a[DATA_W-1];
        sh   <= word_a << 1;
        cnt  <= nbits - CNT_W'(1);
        pend <= 1'b0;
      end else begin
        sd     <= adv_sd;
        sh     <= adv_sh;
        cnt    <= adv_cnt;
        pend   <= 1'b1;
        pend_w <= word_a;
      end
      wbits <= nbits;
      nxt_w <= word_b;
      nxt_v <= word_b_en;
    end else if (launch_ev) begin
      if (pend) begin
        sd   <= pend_w[DATA_W-1];
        sh   <= pend_w << 1;
        cnt  <= wbits - CNT_W'(1);
        pend <= 1'b0;
      end else begin
        sd    <= adv_sd;
        sh    <= adv_sh;
        cnt   <= adv_cnt;
        nxt_v <= adv_nxt_v;
      end
    end
  end

  assign sdata = sd;

  // R7: data moves only on launch or word-start events
  a_r7_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    (!launch_ev && !frame_ev) |=> $stable(sdata));
  // R5: remaining-bit count never exceeds the widest word
  a_r5_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt) < DATA_W);
endmodule

// File: rtl/aser_slave_tx.sv
module aser_slave_tx
  import aser_pkg::*;
#(
  parameter int DATA_W = MAX_WORD
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dclk,
  input  logic              dfs,
  input  logic [1:0]        cfg_fmt,
  input  logic              cfg_fall_capture,
  input  logic              cfg_dsp_late,
  input  logic [1:0]        cfg_wlen,
  input  logic              cfg_hold_last,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_left,
  input  logic [DATA_W-1:0] in_right,
  output logic              in_ready,
  input  logic              underrun_clr,
  output logic              sdata,
  output logic              underrun
);
  localparam int CNT_W = $clog2(DATA_W + 1);

  logic [1:0]        act_fmt, act_wlen;
  logic              act_fall, act_late, act_hold, started;
  logic [DATA_W-1:0] pair_l, pair_r;
  logic              launch_ev, frame_ev, dfs_lvl, left_start, fetch;
  logic [1:0]        use_fmt, use_wlen;
  logic              use_late, use_hold, use_pulse, delay1, under_q;
  logic [CNT_W-1:0]  nbits;
  logic [DATA_W-1:0] left_w, right_w, first_w;

  aser_edge_mon i_edge (
    .clk, .rst_n, .dclk, .dfs,
    .fall_cap   (act_fall),
    .pulse_mode (act_fmt[1]),
    .launch_ev, .frame_ev, .dfs_lvl
  );

  assign left_start = frame_ev &&
    (act_fmt[1] || ((act_fmt == FMT_DLY) ? !dfs_lvl : dfs_lvl));

  // the configuration for the word that starts now
  assign use_fmt   = left_start ? cfg_fmt       : act_fmt;
  assign use_wlen  = left_start ? cfg_wlen      : act_wlen;
  assign use_late  = left_start ? cfg_dsp_late  : act_late;
  assign use_hold  = left_start ? cfg_hold_last : act_hold;
  assign use_pulse = use_fmt[1];
  assign delay1    = use_pulse ? use_late : (use_fmt == FMT_DLY);
  assign nbits     = CNT_W'(word_bits(use_wlen));

  assign fetch   = left_start && in_valid;
  assign left_w  = fetch ? in_left  : (use_hold ? pair_l : '0);
  assign right_w = fetch ? in_right : (use_hold ? pair_r : '0);
  assign first_w = left_start ? left_w : pair_r;

  aser_shift_eng #(.DATA_W(DATA_W), .CNT_W(CNT_W)) i_shift (
    .clk, .rst_n, .launch_ev, .frame_ev,
    .one_slot_delay (delay1),
    .nbits,
    .word_a    (first_w),
    .word_b    (right_w),
    .word_b_en (left_start && use_pulse),
    .sdata
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_fmt  <= FMT_DLY;
      act_wlen <= 2'd1;
      act_fall <= 1'b0;
      act_late <= 1'b0;
      act_hold <= 1'b0;
      started  <= 1'b0;
      pair_l   <= '0;
      pair_r   <= '0;
      under_q  <= 1'b0;
    end else begin
      if (!started || left_start) begin
        act_fmt  <= cfg_fmt;
        act_wlen <= cfg_wlen;
        act_fall <= cfg_fall_capture;
        act_late <= cfg_dsp_late;
        act_hold <= cfg_hold_last;
      end
      if (left_start) begin
        started <= 1'b1;
        pair_l  <= left_w;
        pair_r  <= right_w;
      end
      if (left_start && !in_valid) under_q <= 1'b1;
      else if (underrun_clr)       under_q <= 1'b0;
    end
  end

  assign in_ready = left_start;
  assign underrun = under_q;

  // R8: ready is a single-cycle pulse
  a_r8_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |=> !in_ready);
  // R9: a missed handshake raises the flag
  a_r9_under_set: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !in_valid) |=> underrun);
  // R9: flag holds until cleared
  a_r9_under_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (underrun && !underrun_clr) |=> underrun);
  // R10: active word size moves only at a left-word start
  a_r10_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (started && !left_start) |=> $stable(act_wlen));
endmodule

// File: tb/test_aser_slave_tx.sv
module test_aser_slave_tx;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dclk = 1'b1, dfs = 1'b0;
  logic [1:0] cfg_fmt = 2'd0, cfg_wlen = 2'd1;
  logic cfg_fall_capture = 1'b0, cfg_dsp_late = 1'b0, cfg_hold_last = 1'b0;
  logic in_valid = 1'b0;
  logic [23:0] in_left = '0, in_right = '0;
  logic in_ready, sdata, underrun;
  logic underrun_clr = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  aser_slave_tx i_aser_slave_tx (
    .clk, .rst_n, .dclk, .dfs, .cfg_fmt, .cfg_fall_capture, .cfg_dsp_late,
    .cfg_wlen, .cfg_hold_last, .in_valid, .in_left, .in_right, .in_ready,
    .underrun_clr, .sdata, .underrun
  );

  int n_cmp = 0, n_bad = 0;
  string tag = "R1";

  bit expq[$];
  logic [23:0] src_l[$], src_r[$];
  bit hs_pend = 0;
  int accepted = 0, seen_ready = 0, m_fetch = 0, m_lefts = 0;
  logic [23:0] m_pl, m_pr;
  logic [1:0] m_fmt, m_wlen;
  bit m_late, m_started, m_under, last_bit;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
    end
  endtask

  // source side of the handshake: the pair leaves the queue after it was taken
  always @(negedge clk) begin
    if (hs_pend) begin
      void'(src_l.pop_front());
      void'(src_r.pop_front());
      accepted++;
    end
    hs_pend = rst_n && in_valid && in_ready;
    if (rst_n && in_ready) seen_ready++;
    in_valid = (src_l.size() > 0);
    if (src_l.size() > 0) begin
      in_left  = src_l[0];
      in_right = src_r[0];
    end
  end

  function automatic int nb(logic [1:0] c);
    case (c) 2'd0: return 8; 2'd1: return 16; 2'd2: return 20; default: return 24; endcase
  endfunction

  task automatic push_word(logic [23:0] w, int n);
    for (int i = 0; i < n; i++) expq.push_back(w[23-i]);
  endtask

  // behavioural frame model: a queue of the bits the receiver will capture
  task automatic model_event(logic d_old, logic d_new);
    logic [1:0] af;
    bit ev, left, dly, keep;
    af = m_started ? m_fmt : cfg_fmt;
    if (af[1]) begin ev = !d_old && d_new; left = 1; end
    else begin ev = (d_old != d_new); left = (af == 2'd0) ? !d_new : d_new; end
    if (!ev) return;
    if (left) begin
      m_fmt = cfg_fmt; m_wlen = cfg_wlen; m_late = cfg_dsp_late; m_started = 1;
      m_lefts++;
      if (src_l.size() > 0) begin m_pl = src_l[0]; m_pr = src_r[0]; m_fetch++; end
      else begin
        m_under = 1;
        if (!cfg_hold_last) begin m_pl = '0; m_pr = '0; end
      end
    end
    af = m_started ? m_fmt : cfg_fmt;
    dly = af[1] ? (m_started ? m_late : cfg_dsp_late) : (af == 2'd0);
    if (dly) begin
      keep = (expq.size() > 0) ? expq[0] : 1'b0;
      expq.delete();
      expq.push_back(keep);
    end else expq.delete();
    push_word(left ? m_pl : m_pr, nb(m_started ? m_wlen : cfg_wlen));
    if (af[1]) push_word(m_pr, nb(m_wlen));
  endtask

  task automatic bit_slot(logic d_new);
    logic d_old;
    bit e;
    chk({tag, " R7 hold to launch"}, sdata, last_bit);
    d_old = dfs;
    dclk = cfg_fall_capture ? 1'b1 : 1'b0;
    dfs = d_new;
    model_event(d_old, d_new);
    repeat (HALF) @(negedge clk);
    e = (expq.size() > 0) ? expq.pop_front() : 1'b0;
    chk({tag, " capture bit"}, sdata, e);
    last_bit = e;
    dclk = cfg_fall_capture ? 1'b0 : 1'b1;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic half_word(logic lvl, int n);
    for (int i = 0; i < n; i++) bit_slot(lvl);
  endtask

  task automatic run_lr(int frames, int bph);
    logic ll;
    ll = (cfg_fmt == 2'd0) ? 1'b0 : 1'b1;
    for (int f = 0; f < frames; f++) begin
      half_word(ll, bph);
      half_word(!ll, bph);
    end
  endtask

  task automatic run_pulse(int frames, int bpf);
    for (int f = 0; f < frames; f++) begin
      bit_slot(1'b1);
      half_word(1'b0, bpf - 1);
    end
  endtask

  task automatic push_pairs(int n, int seed);
    for (int i = 0; i < n; i++) begin
      src_l.push_back(24'hA5_3C_96 ^ (24'(seed + i) * 24'h01_2F_4B));
      src_r.push_back(24'h5A_C3_69 ^ (24'(seed + i) * 24'h03_71_D5));
    end
  endtask

  task automatic do_reset(logic [1:0] fmt, logic [1:0] wl, logic fall, logic late, logic hold);
    @(negedge clk);
    rst_n = 1'b0;
    cfg_fmt = fmt; cfg_wlen = wl; cfg_fall_capture = fall;
    cfg_dsp_late = late; cfg_hold_last = hold;
    dfs = 1'b0;
    dclk = fall ? 1'b0 : 1'b1;
    src_l.delete(); src_r.delete(); expq.delete();
    hs_pend = 0;
    m_started = 0; m_pl = '0; m_pr = '0; m_under = 0; last_bit = 0;
    m_fetch = 0; m_lefts = 0; accepted = 0; seen_ready = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset sdata", sdata, 1'b0);
    chk("R1 reset in_ready", in_ready, 1'b0);
    chk("R1 reset underrun", underrun, 1'b0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic end_checks(string req);
    repeat (4) @(negedge clk);
    chk({req, " R8 ready pulses"}, seen_ready, m_lefts);
    chk({req, " R8 pairs accepted"}, accepted, m_fetch);
    chk({req, " R9 underrun flag"}, underrun, m_under);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    // R2 R5 R6: delayed framing, 16-bit, idle slots then back-to-back halves
    do_reset(2'd0, 2'd1, 1'b0, 1'b0, 1'b0);
    tag = "R2 R5 R6";
    push_pairs(8, 1);
    run_lr(4, 20);
    run_lr(3, 16);
    end_checks("R2");

    // R3 R5 R6: aligned framing, 24-bit, tight then padded
    do_reset(2'd1, 2'd3, 1'b0, 1'b0, 1'b0);
    tag = "R3 R5 R6";
    push_pairs(6, 20);
    run_lr(3, 24);
    run_lr(2, 30);
    end_checks("R3");

    // R4: pulse framing, early MSB, 8-bit
    do_reset(2'd2, 2'd0, 1'b0, 1'b0, 1'b0);
    tag = "R4 R5 early";
    push_pairs(5, 40);
    run_pulse(4, 20);
    end_checks("R4");

    // R4: pulse framing, late MSB, 20-bit, frame of 2W+1 slots
    do_reset(2'd3, 2'd2, 1'b0, 1'b1, 1'b0);
    tag = "R4 R5 late";
    push_pairs(5, 60);
    run_pulse(4, 41);
    end_checks("R4");

    // R7: falling-edge capture, delayed framing 20-bit and pulse late 8-bit
    do_reset(2'd0, 2'd2, 1'b1, 1'b0, 1'b0);
    tag = "R7 R2";
    push_pairs(4, 80);
    run_lr(3, 24);
    end_checks("R7");
    do_reset(2'd2, 2'd0, 1'b1, 1'b1, 1'b0);
    tag = "R7 R4";
    push_pairs(4, 90);
    run_pulse(3, 18);
    end_checks("R7");

    // R9: underrun with zeros, clear, then repeat-last policy
    do_reset(2'd0, 2'd1, 1'b0, 1'b0, 1'b0);
    tag = "R9 zeros";
    run_lr(2, 20);
    end_checks("R9");
    @(negedge clk) underrun_clr = 1'b1;
    @(negedge clk) underrun_clr = 1'b0;
    m_under = 0;
    @(negedge clk);
    chk("R9 cleared", underrun, 1'b0);
    cfg_hold_last = 1'b1;
    tag = "R9 repeat";
    push_pairs(1, 100);
    run_lr(4, 20);
    end_checks("R9");

    // R10: word size changed mid-frame applies from the next left word
    do_reset(2'd1, 2'd1, 1'b0, 1'b0, 1'b0);
    tag = "R10";
    push_pairs(4, 120);
    run_lr(1, 26);
    half_word(1'b1, 13);
    cfg_wlen = 2'd3;
    half_word(1'b1, 13);
    half_word(1'b0, 26);
    run_lr(2, 26);
    end_checks("R10");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule